// File: doc/BRIEF.md
# Loop-Unrolled Decision Feedback Equalizer

This block decides binary NRZ symbols from signed samples that arrive at most one per clock from an upstream converter or linear equalizer. The feedback taps closest to the current symbol are resolved by speculation. The sample goes to a bank of comparators, one for each possible pattern of the most recent decisions, and each comparator has its own precomputed threshold. The true decision history then selects one comparator result. Taps further back are cancelled in the usual way: their weights are subtracted from the sample before it reaches the comparators.

For every symbol the block reports whether all of its comparators agreed. Agreement means the symbol had vertical margin against every hypothesis. Disagreement counts as low margin, and a saturating counter accumulates those symbols for lane margining and for guiding adaptation. The tap weights come from outside the block. They are captured only on cycles with no valid sample, so they never change while a symbol is being resolved.

Top module: `unrolled_dfe`

## Requirements
- R1: After reset, `valid_o` is 0, `lowm_cnt_o` is 0, the weight registers are 0, and every stored past decision is 0. A stored 0 counts as a -1 symbol when the first valid sample is decided.
- R2: A sample accepted with `valid_i`=1 produces `valid_o`=1 on the next clock, together with its `bit_o` and `agree_o`. On a cycle with `valid_i`=0, `valid_o` is 0 one clock later and the decision history does not shift.
- R3: Let d_k be the decision made k symbols ago, mapped to +1 for bit 1 and -1 for bit 0. The equalized value is y = sample minus the sum of `sub_wt_i` tap j times d_(N_UNR+1+j). Tap j occupies bits [j*DW +: DW].
- R4: Threshold pattern p is the sum over k of `unr_wt_i` tap k times s_k, where s_k is +1 if bit k of p is 1 and -1 otherwise. Tap k occupies bits [k*DW +: DW]. Comparator p outputs 1 when y >= threshold p. The decision is comparator p with p = {d_N_UNR, ..., d_1} as bits, d_1 in bit 0.
- R5: Every partial sum, for both the equalized value and the thresholds, saturates to a DW+2-bit signed range. Each final value saturates to the DW-bit signed sample range. Nothing wraps.
- R6: `agree_o` is 1 exactly when all 2^N_UNR comparators gave the same value for that symbol.
- R7: `lowm_cnt_o` increments by one for each valid symbol with `agree_o`=0 and holds at its all-ones value. It updates on the same clock edge as the symbol's outputs.
- R8: `cnt_clr_i`=1 sets the counter to 0 on the next clock edge and takes priority over an increment in the same cycle.
- R9: The weights are registered only on cycles with `valid_i`=0. A change on `unr_wt_i` or `sub_wt_i` during a run of valid samples has no effect until an idle cycle has passed.
- R10: Back-to-back valid samples each use the decision of the immediately preceding sample. The feedback path adds no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; low marks an idle cycle |
| sample_i | input | DW | Signed input sample |
| unr_wt_i | input | N_UNR*DW | Signed weights of the unrolled taps, nearest tap at bit 0 |
| sub_wt_i | input | N_SUB*DW | Signed weights of the subtractive taps |
| cnt_clr_i | input | 1 | Clear pulse for the low-margin counter |
| valid_o | output | 1 | Output strobe |
| bit_o | output | 1 | Decided symbol |
| agree_o | output | 1 | 1 when all comparators agreed (high margin) |
| lowm_cnt_o | output | CNT_W | Saturating count of low-margin symbols |

N_UNR is 1 or 2 and N_SUB is 1 to 4.

## Verification
The first symbol after reset uses a threshold set that gives opposite decisions for a -1 history and a +1 history. A design that started from any other history decides that symbol wrongly.

Large weights are combined with extreme samples to drive the sums past the sample range. Wrapping arithmetic would flip decisions that saturation keeps correct. Weights are also changed in the middle of a burst, and the bench expects the old weights to stay in force until an idle cycle, so a design that loads them early is caught.

The counter is pushed to its ceiling and then cleared in the same cycle as a low-margin symbol. A counter that rolls over, or that lets the increment win over the clear, reports the wrong count.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int unsigned GUARD_BITS = 2;
  typedef enum logic {SYM_NEG = 1'b0, SYM_POS = 1'b1} sym_e;
endpackage

// File: rtl/dfe_sub_fb.sv
module dfe_sub_fb
  import dfe_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned N_UNR = 2,
  parameter int unsigned N_SUB = 2,
  localparam int unsigned NH = N_UNR + N_SUB
) (
  input  logic [DW-1:0]       sample_i,
  input  logic [NH-1:0]       hist_i,
  input  logic [N_SUB*DW-1:0] wt_i,
  output logic [DW-1:0]       eq_o
);
  localparam int unsigned GW = DW + GUARD_BITS;

  logic [GW-1:0] acc;
  logic [GW:0]   t;
  logic [DW-1:0] w;

  always_comb begin
    acc = {{GUARD_BITS{sample_i[DW-1]}}, sample_i};
    t   = '0;
    w   = '0;
    for (int j = 0; j < int'(N_SUB); j++) begin
      w = wt_i[j*DW +: DW];
      // d=+1 removes +w, d=-1 removes -w
      if (sym_e'(hist_i[N_UNR+j]) == SYM_POS)
        t = {acc[GW-1], acc} - {{(GW+1-DW){w[DW-1]}}, w};
      else
        t = {acc[GW-1], acc} + {{(GW+1-DW){w[DW-1]}}, w};
      if (t[GW] != t[GW-1])
        acc = t[GW] ? {1'b1, {(GW-1){1'b0}}} : {1'b0, {(GW-1){1'b1}}};
      else
        acc = t[GW-1:0];
    end
    if (acc[GW-1:DW-1] != {(GUARD_BITS+1){1'b0}} &&
        acc[GW-1:DW-1] != {(GUARD_BITS+1){1'b1}})
      eq_o = acc[GW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      eq_o = acc[DW-1:0];
  end
endmodule

// File: rtl/dfe_thr_bank.sv
module dfe_thr_bank
  import dfe_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned N_UNR = 2,
  localparam int unsigned NP = 1 << N_UNR
) (
  input  logic [N_UNR*DW-1:0] wt_i,
  output logic [NP*DW-1:0]    thr_o
);
  localparam int unsigned GW = DW + GUARD_BITS;

  for (genvar p = 0; p < NP; p++) begin : g_pat
    localparam logic [N_UNR-1:0] PAT = p[N_UNR-1:0];
    logic [GW-1:0] acc;
    logic [GW:0]   t;
    logic [DW-1:0] w;

    always_comb begin
      acc = '0;
      t   = '0;
      w   = '0;
      for (int k = 0; k < int'(N_UNR); k++) begin
        w = wt_i[k*DW +: DW];
        if (PAT[k])
          t = {acc[GW-1], acc} + {{(GW+1-DW){w[DW-1]}}, w};
        else
          t = {acc[GW-1], acc} - {{(GW+1-DW){w[DW-1]}}, w};
        if (t[GW] != t[GW-1])
          acc = t[GW] ? {1'b1, {(GW-1){1'b0}}} : {1'b0, {(GW-1){1'b1}}};
        else
          acc = t[GW-1:0];
      end
      if (acc[GW-1:DW-1] != {(GUARD_BITS+1){1'b0}} &&
          acc[GW-1:DW-1] != {(GUARD_BITS+1){1'b1}})
        thr_o[p*DW +: DW] = acc[GW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      else
        thr_o[p*DW +: DW] = acc[DW-1:0];
    end
  end
endmodule

// File: rtl/dfe_slicer_bank.sv
module dfe_slicer_bank #(
  parameter int unsigned DW    = 8,
  parameter int unsigned N_UNR = 2,
  localparam int unsigned NP = 1 << N_UNR
) (
  input  logic [DW-1:0]    eq_i,
  input  logic [NP*DW-1:0] thr_i,
  input  logic [N_UNR-1:0] sel_i,
  output logic             dec_o,
  output logic             agree_o
);
  logic [NP-1:0] cmp;

  for (genvar p = 0; p < NP; p++) begin : g_cmp
    assign cmp[p] = $signed(eq_i) >= $signed(thr_i[p*DW +: DW]);
  end

  assign dec_o   = cmp[sel_i];
  assign agree_o = (&cmp) | ~(|cmp);
endmodule

// File: rtl/dfe_margin_ctr.sv
module dfe_margin_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  a_r7_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q && !clr_i) |=> &cnt_q);
  a_r7_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/unrolled_dfe.sv
module unrolled_dfe #(
  parameter int unsigned DW    = 8,
  parameter int unsigned N_UNR = 2,
  parameter int unsigned N_SUB = 2,
  parameter int unsigned CNT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [DW-1:0]       sample_i,
  input  logic [N_UNR*DW-1:0] unr_wt_i,
  input  logic [N_SUB*DW-1:0] sub_wt_i,
  input  logic                cnt_clr_i,
  output logic                valid_o,
  output logic                bit_o,
  output logic                agree_o,
  output logic [CNT_W-1:0]    lowm_cnt_o
);
  localparam int unsigned NH = N_UNR + N_SUB;
  localparam int unsigned NP = 1 << N_UNR;

  logic [N_UNR*DW-1:0] unr_wt_q;
  logic [N_SUB*DW-1:0] sub_wt_q;
  logic [NH-1:0]       hist_q;
  logic [DW-1:0]       eq_s;
  logic [NP*DW-1:0]    thr_s;
  logic                dec_s, agr_s;

  // weights only move while no symbol is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unr_wt_q <= '0;
      sub_wt_q <= '0;
    end else if (!valid_i) begin
      unr_wt_q <= unr_wt_i;
      sub_wt_q <= sub_wt_i;
    end
  end

  dfe_thr_bank #(.DW(DW), .N_UNR(N_UNR)) u_thr (
    .wt_i  (unr_wt_q),
    .thr_o (thr_s)
  );

  dfe_sub_fb #(.DW(DW), .N_UNR(N_UNR), .N_SUB(N_SUB)) u_sub (
    .sample_i (sample_i),
    .hist_i   (hist_q),
    .wt_i     (sub_wt_q),
    .eq_o     (eq_s)
  );

  dfe_slicer_bank #(.DW(DW), .N_UNR(N_UNR)) u_slc (
    .eq_i    (eq_s),
    .thr_i   (thr_s),
    .sel_i   (hist_q[N_UNR-1:0]),
    .dec_o   (dec_s),
    .agree_o (agr_s)
  );

  dfe_margin_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (valid_i & ~agr_s),
    .clr_i  (cnt_clr_i),
    .cnt_o  (lowm_cnt_o)
  );

  // decision loop closes in one cycle: hist_q feeds the very next sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
      agree_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hist_q  <= {hist_q[NH-2:0], dec_s};
        bit_o   <= dec_s;
        agree_o <= agr_s;
      end
    end
  end

  a_r2_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hist_q));
  a_r9_wt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($stable(unr_wt_q) && $stable(sub_wt_q)));
  a_r10_hist_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> hist_q[0] == bit_o);
  a_r6_agree_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && agr_s) |-> dec_s == (($signed(eq_s) >= $signed(thr_s[DW-1:0]))));
endmodule

// File: tb/unrolled_dfe_test.sv
`timescale 1ns/1ps
module unrolled_dfe_test;
  localparam int DW = 8, NU = 2, NS = 2, CW = 4, NH = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, cnt_clr_i = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic [NU*DW-1:0] unr_wt_i = '0;
  logic [NS*DW-1:0] sub_wt_i = '0;
  logic valid_o, bit_o, agree_o;
  logic [CW-1:0] lowm_cnt_o;

  int checks = 0, fails = 0;
  int m_hist[NH];
  int m_h[NU], m_w[NS], m_cnt;
  int in_h[NU], in_w[NS];
  bit q_b[$]; bit q_a[$]; int q_c[$]; string q_t[$];

  always #2.5 clk = ~clk;

  unrolled_dfe #(.DW(DW), .N_UNR(NU), .N_SUB(NS), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .unr_wt_i(unr_wt_i), .sub_wt_i(sub_wt_i), .cnt_clr_i(cnt_clr_i),
    .valid_o(valid_o), .bit_o(bit_o), .agree_o(agree_o), .lowm_cnt_o(lowm_cnt_o));

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_w(int h1, int h2, int w1, int w2);
    in_h[0] = h1; in_h[1] = h2; in_w[0] = w1; in_w[1] = w2;
    unr_wt_i = {8'(h2), 8'(h1)};
    sub_wt_i = {8'(w2), 8'(w1)};
  endtask

  task automatic model(int s, output bit b, output bit ag);
    int y, thr, pat;
    bit c[4];
    y = s;
    for (int j = 0; j < NS; j++)
      y = clampi(y - m_w[j] * (m_hist[NU+j] ? 1 : -1), -512, 511);
    y = clampi(y, -128, 127);
    for (int p = 0; p < 4; p++) begin
      thr = 0;
      for (int k = 0; k < NU; k++)
        thr = clampi(thr + m_h[k] * (((p >> k) & 1) ? 1 : -1), -512, 511);
      thr = clampi(thr, -128, 127);
      c[p] = (y >= thr);
    end
    pat = m_hist[0] + 2 * m_hist[1];
    b  = c[pat];
    ag = (c[0] == c[1]) && (c[1] == c[2]) && (c[2] == c[3]);
  endtask

  task automatic send(int s, string tag, bit clr = 1'b0);
    bit b, ag;
    @(negedge clk);
    valid_i = 1'b1; sample_i = 8'(s); cnt_clr_i = clr;
    model(s, b, ag);
    for (int k = NH - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = b;
    if (clr) m_cnt = 0;
    else if (!ag && m_cnt < CMAX) m_cnt++;
    q_b.push_back(b); q_a.push_back(ag); q_c.push_back(m_cnt); q_t.push_back(tag);
  endtask

  task automatic idle(int n, bit clr = 1'b0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) chk(valid_o == 1'b0, "R2", "valid_o idle", int'(valid_o), 0);
      valid_i = 1'b0; cnt_clr_i = clr;
      for (int k = 0; k < NU; k++) m_h[k] = in_h[k];
      for (int j = 0; j < NS; j++) m_w[j] = in_w[j];
      if (clr) m_cnt = 0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (q_b.size() == 0) begin
        chk(1'b0, "R2", "unexpected valid_o", 1, 0);
      end else begin
        string t;
        bit eb, ea;
        int ec;
        eb = q_b.pop_front(); ea = q_a.pop_front(); ec = q_c.pop_front(); t = q_t.pop_front();
        chk(bit_o == eb, t, "bit_o", int'(bit_o), int'(eb));
        chk(agree_o == ea, {t, "/R6"}, "agree_o", int'(agree_o), int'(ea));
        chk(int'(lowm_cnt_o) == ec, {t, "/R7"}, "lowm_cnt_o", int'(lowm_cnt_o), ec);
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NH; k++) m_hist[k] = 0;
    for (int k = 0; k < NU; k++) m_h[k] = 0;
    for (int j = 0; j < NS; j++) m_w[j] = 0;
    m_cnt = 0;
    set_w(40, 20, 0, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1", "valid_o reset", int'(valid_o), 0);
    chk(lowm_cnt_o == '0, "R1", "lowm_cnt_o reset", int'(lowm_cnt_o), 0);
    idle(2);
    // r1_: -1,-1 history gives threshold -60, so -50 decides 1
    send(-50, "R1");
    // R4/R10 mixed burst over every history pattern
    send(100, "R4"); send(0, "R10"); send(-100, "R4"); send(30, "R10");
    send(-30, "R4"); send(0, "R10"); send(70, "R4"); send(-70, "R10");
    send(-10, "R4"); send(10, "R10");
    idle(3);
    send(0, "R2"); send(-25, "R2");
    // R3: subtractive taps
    set_w(40, 20, 30, -25);
    idle(2);
    send(10, "R3"); send(-60, "R3"); send(45, "R3"); send(-5, "R3");
    send(80, "R3"); send(-80, "R3"); send(25, "R3"); send(-35, "R3");
    // R9: change weights inside a burst, old set must hold
    send(15, "R9");
    set_w(90, 90, 90, 90);
    send(-15, "R9"); send(50, "R9"); send(-45, "R9"); send(5, "R9");
    idle(2);
    send(15, "R9"); send(-15, "R9"); send(60, "R9"); send(-100, "R9");
    // R5: saturation of sums and thresholds
    set_w(100, 100, 127, -128);
    idle(2);
    send(127, "R5"); send(-128, "R5"); send(127, "R5"); send(-128, "R5");
    send(120, "R5"); send(-120, "R5"); send(0, "R5"); send(127, "R5");
    // R7: counter climbs to all ones and holds
    set_w(40, 20, 0, 0);
    idle(2, 1'b1);
    for (int i = 0; i < 20; i++) send(0, "R7");
    // R8: clear beats coinciding increment
    send(0, "R8", 1'b1);
    send(0, "R8");
    idle(1, 1'b1);
    send(100, "R8");
    idle(3);
    chk(q_b.size() == 0, "R2", "pending outputs", q_b.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule